// File: doc/BRIEF.md
# Q subcode serial readout port

This block sits between a disc subcode decoder and a host microcontroller. Each time the decoder delivers a complete 80-bit Q channel frame with its 16-bit check word, the block stores the frame and checks it. It raises a ready flag when the frame is fit for the host to use. The host then reads the frame one bit at a time. It drives a read clock, a read/write strobe, a chip select and a bit-order select. After the 80 frame bits the host can clock out a 16-bit audio meter word.

The meter runs in one of two modes. In level mode it keeps the largest magnitude seen separately for the left and right channels, and it reports them in turn. In peak mode it keeps one maximum over both channels, and a mask can stop that maximum from growing. While the host is reading, the stored frame is frozen and new frames are dropped. A short pulse on the strobe ends the read and allows updates again. All host inputs are taken as already synchronous to `clk`.

Top module: `qsub_readout`

## Requirements
- R1: After a frame strobe, `q_ready_o` is 1 only when the check passes and the address nibble equals 1. The address nibble is bits [3:0] of `frame_bits_i`. The check passes when `frame_crc_i` equals the bitwise inverse of a CRC-16. This CRC uses polynomial 0x1021 and initial value 0, and it is taken over the frame starting at bit 79 and ending at bit 0. The flag is updated on the same clock edge that samples the strobe.
- R2: Command codes on `cmd_op_i` take effect when `cmd_valid_i` is high. Code 2 selects address-free mode, in which the address nibble is not checked. Code 1 restores the address check. After reset the address check is active.
- R3: The first falling edge of `host_clk_i` while `host_cs_n_i` is low freezes the stored frame. Frames that arrive while frozen are dropped, and `q_ready_o` keeps its value. A falling edge of `host_rw_i` ends the freeze, rewinds the read position and clears `q_ready_o`.
- R4: The output stream has 96 positions: frame bytes 0 to 9, where byte k is `frame_bits_i[8k+7:8k]`, then the meter word. With `host_msb_first_i` low, each byte goes bit 0 first and the meter word goes bit 0 first. With it high, both go most significant bit first. The first falling edge shows position 0. Each later falling edge moves to the next position, and the position stops at 95.
- R5: In level mode the meter word is {channel, 15-bit magnitude}. The channel bit is 1 for left and 0 for right. The magnitude is the absolute value of the signed sample, with -32768 limited to 32767. Each channel holds its own maximum.
- R6: In level mode, when a read of all 96 positions is ended by the strobe, the hold of the channel just reported is cleared and the reported channel swaps. Left is reported first after reset.
- R7: In peak mode the meter word is {0, maximum magnitude over both channels}. Reading neither clears it nor changes it.
- R8: Code 5 sets the peak mask, and while it is set the peak value does not change. Code 6 clears the mask.
- R9: Code 4 selects peak mode and clears both level holds. Code 3 selects level mode and clears the peak. Holds update only in their own mode. Reset gives level mode, no mask and all holds at 0.
- R10: While `host_cs_n_i` is high, `sq_drive_o` is 0, `sq_dout_o` is 0 and host clock edges have no effect.
- R11: The meter word is captured at the first falling edge of a read. Samples that arrive during the read do not change the word being read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset |
| frame_valid_i | input | 1 | Frame strobe |
| frame_bits_i | input | 80 | Q frame bits |
| frame_crc_i | input | 16 | Stored (inverted) check word |
| cmd_valid_i | input | 1 | Command strobe |
| cmd_op_i | input | 3 | Command code |
| smp_valid_i | input | 1 | Audio sample strobe |
| smp_left_i | input | 16 | Signed left sample |
| smp_right_i | input | 16 | Signed right sample |
| host_clk_i | input | 1 | Host read clock, idles high |
| host_rw_i | input | 1 | Host read/write strobe |
| host_cs_n_i | input | 1 | Active-low chip select |
| host_msb_first_i | input | 1 | Bit order select |
| q_ready_o | output | 1 | Frame ready flag |
| sq_dout_o | output | 1 | Serial data |
| sq_drive_o | output | 1 | Output enable; 0 means the data pin is released to high impedance |

## Verification
The bench builds the block with its default parameters: an 80-bit frame and 16-bit samples. This gives the full 96-position read, both byte orders across all ten frame bytes, and the -32768 sample that exercises magnitude limiting. Random frames mix good and corrupted check words with address nibbles of 1 and other values. Directed cases cover a frame that arrives during a read, clocking with chip select high, the mask, and mode switches between meter modes.

// File: rtl/qsub_pkg.sv
package qsub_pkg;
  typedef enum logic [2:0] {
    OP_NONE      = 3'd0,
    OP_ADDR_ONE  = 3'd1,
    OP_ADDR_FREE = 3'd2,
    OP_LEVEL     = 3'd3,
    OP_PEAK      = 3'd4,
    OP_MASK_ON   = 3'd5,
    OP_MASK_OFF  = 3'd6,
    OP_RSVD      = 3'd7
  } qsub_op_e;

  typedef enum logic {
    MTR_LEVEL = 1'b0,
    MTR_PEAK  = 1'b1
  } qsub_mtr_e;

  localparam logic [15:0] CRC_POLY = 16'h1021;
endpackage

// File: rtl/qsub_crc_gate.sv
module qsub_crc_gate #(
  parameter int FRAME_BITS = 80
) (
  input  logic [FRAME_BITS-1:0] frame_i,
  input  logic [15:0]           crc_word_i,
  input  logic                  addr_free_i,
  output logic                  crc_ok_o,
  output logic                  adr_ok_o,
  output logic                  accept_ok_o
);
  import qsub_pkg::*;

  // Serial CRC over the frame, highest bit first, zero preset.
  function automatic logic [15:0] crc_of(input logic [FRAME_BITS-1:0] d);
    logic [15:0] c;
    logic        fb;
    c = '0;
    for (int i = FRAME_BITS - 1; i >= 0; i--) begin
      fb = c[15] ^ d[i];
      c  = {c[14:0], 1'b0} ^ (fb ? CRC_POLY : 16'h0000);
    end
    return c;
  endfunction

  assign crc_ok_o    = (crc_of(frame_i) == ~crc_word_i);
  assign adr_ok_o    = (frame_i[3:0] == 4'd1);
  assign accept_ok_o = crc_ok_o && (addr_free_i || adr_ok_o);
endmodule

// File: rtl/qsub_meter.sv
module qsub_meter #(
  parameter int SAMPLE_W = 16
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                smp_valid_i,
  input  logic [SAMPLE_W-1:0] smp_left_i,
  input  logic [SAMPLE_W-1:0] smp_right_i,
  input  logic                cmd_valid_i,
  input  logic [2:0]          cmd_op_i,
  input  logic                read_done_i,
  output logic [SAMPLE_W-1:0] meter_word_o
);
  import qsub_pkg::*;

  localparam int MAG_W = SAMPLE_W - 1;

  // Absolute value with the most negative code limited to full scale.
  function automatic logic [MAG_W-1:0] mag_of(input logic [SAMPLE_W-1:0] s);
    logic [SAMPLE_W-1:0] n;
    n = -s;
    if (!s[SAMPLE_W-1])     return s[MAG_W-1:0];
    else if (n[SAMPLE_W-1]) return '1;
    else                    return n[MAG_W-1:0];
  endfunction

  logic [MAG_W-1:0] lvl_l_q, lvl_r_q, peak_q;
  logic             chan_l_q, mask_q;
  qsub_mtr_e        mode_q;
  qsub_op_e         op;

  logic [MAG_W-1:0] mag_l, mag_r, mag_max;
  assign mag_l   = mag_of(smp_left_i);
  assign mag_r   = mag_of(smp_right_i);
  assign mag_max = (mag_l > mag_r) ? mag_l : mag_r;
  assign op      = qsub_op_e'(cmd_op_i);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lvl_l_q  <= '0;
      lvl_r_q  <= '0;
      peak_q   <= '0;
      chan_l_q <= 1'b1;
      mask_q   <= 1'b0;
      mode_q   <= MTR_LEVEL;
    end else begin
      if (smp_valid_i) begin
        if (mode_q == MTR_LEVEL) begin
          if (mag_l > lvl_l_q) lvl_l_q <= mag_l;
          if (mag_r > lvl_r_q) lvl_r_q <= mag_r;
        end else if (!mask_q && (mag_max > peak_q)) begin
          peak_q <= mag_max;
        end
      end
      if (read_done_i && (mode_q == MTR_LEVEL)) begin
        if (chan_l_q) lvl_l_q <= '0;
        else          lvl_r_q <= '0;
        chan_l_q <= ~chan_l_q;
      end
      if (cmd_valid_i) begin
        case (op)
          OP_LEVEL:    begin mode_q <= MTR_LEVEL; peak_q <= '0; end
          OP_PEAK:     begin mode_q <= MTR_PEAK; lvl_l_q <= '0; lvl_r_q <= '0; end
          OP_MASK_ON:  mask_q <= 1'b1;
          OP_MASK_OFF: mask_q <= 1'b0;
          default:     ;
        endcase
      end
    end
  end

  assign meter_word_o = (mode_q == MTR_PEAK) ? {1'b0, peak_q}
                      : {chan_l_q, (chan_l_q ? lvl_l_q : lvl_r_q)};

  // R8: a masked peak in steady peak mode never moves.
  p_mask_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (mask_q && $past(mask_q) && mode_q == MTR_PEAK && $past(mode_q) == MTR_PEAK)
      |-> $stable(peak_q));

  // R7: the peak never falls while peak mode is kept.
  p_peak_mono_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q == MTR_PEAK && $past(mode_q) == MTR_PEAK) |-> (peak_q >= $past(peak_q)));

  // R6: a full level read of the left channel clears it and swaps channel.
  p_lvl_clear_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (read_done_i && mode_q == MTR_LEVEL && chan_l_q) |=> (lvl_l_q == '0 && !chan_l_q));
endmodule

// File: rtl/qsub_shifter.sv
module qsub_shifter #(
  parameter int FRAME_BITS = 80,
  parameter int WORD_W     = 16
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  host_clk_i,
  input  logic                  host_rw_i,
  input  logic                  host_cs_n_i,
  input  logic                  host_msb_first_i,
  input  logic                  load_i,
  input  logic [FRAME_BITS-1:0] frame_i,
  input  logic [WORD_W-1:0]     meter_word_i,
  output logic                  frozen_o,
  output logic                  release_o,
  output logic                  read_done_o,
  output logic                  sq_dout_o,
  output logic                  sq_drive_o
);
  localparam int TOTAL = FRAME_BITS + WORD_W;
  localparam int PTR_W = $clog2(TOTAL);
  localparam int OFF_W = $clog2(WORD_W);
  localparam logic [PTR_W-1:0] LAST_POS  = PTR_W'(TOTAL - 1);
  localparam logic [PTR_W-1:0] FRAME_END = PTR_W'(FRAME_BITS);
  localparam logic [OFF_W-1:0] WORD_TOP  = OFF_W'(WORD_W - 1);

  logic [FRAME_BITS-1:0] q_hold;
  logic [WORD_W-1:0]     snap_q;
  logic [PTR_W-1:0]      ptr_q;
  logic                  started_q, hclk_q, rw_q;

  // Named host events for the assertions.
  logic h_fall, rw_fall;
  assign h_fall  = hclk_q && !host_clk_i && !host_cs_n_i;
  assign rw_fall = rw_q && !host_rw_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hclk_q    <= 1'b1;
      rw_q      <= 1'b0;
      started_q <= 1'b0;
      ptr_q     <= '0;
      snap_q    <= '0;
      q_hold    <= '0;
    end else begin
      hclk_q <= host_clk_i;
      rw_q   <= host_rw_i;
      if (load_i) q_hold <= frame_i;
      if (rw_fall) begin
        started_q <= 1'b0;
        ptr_q     <= '0;
      end else if (h_fall) begin
        if (!started_q) begin
          started_q <= 1'b1;
          snap_q    <= meter_word_i;
        end else if (ptr_q != LAST_POS) begin
          ptr_q <= ptr_q + 1'b1;
        end
      end
    end
  end

  logic [PTR_W-1:0] base, idx;
  logic [2:0]       pos;
  logic [OFF_W-1:0] off;
  logic             bit_sel;

  always_comb begin
    base    = {ptr_q[PTR_W-1:3], 3'b000};
    pos     = ptr_q[2:0];
    off     = OFF_W'(ptr_q - FRAME_END);
    idx     = host_msb_first_i ? (base | PTR_W'(3'd7 - pos)) : (base | PTR_W'(pos));
    if (ptr_q < FRAME_END) bit_sel = q_hold[idx];
    else                   bit_sel = snap_q[host_msb_first_i ? (WORD_TOP - off) : off];
  end

  assign frozen_o    = started_q;
  assign release_o   = rw_fall;
  assign read_done_o = rw_fall && started_q && (ptr_q == LAST_POS);
  assign sq_drive_o  = !host_cs_n_i;
  assign sq_dout_o   = host_cs_n_i ? 1'b0 : bit_sel;

  // R3: a frozen register keeps its contents.
  p_hold_frozen_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (started_q && $past(started_q)) |-> $stable(q_hold));

  // R4: each falling host edge inside a read advances one position.
  p_ptr_step_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (h_fall && started_q && ptr_q != LAST_POS && !rw_fall)
      |=> (ptr_q == $past(ptr_q) + PTR_W'(1)));

  // R4: the position never passes the last bit.
  p_ptr_range_r4: assert property (@(posedge clk) disable iff (!rst_n)
    ptr_q <= LAST_POS);

  // R11: the meter word being read stays put during a read.
  p_snap_stable_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (started_q && $past(started_q)) |-> $stable(snap_q));
endmodule

// File: rtl/qsub_readout.sv
module qsub_readout #(
  parameter int FRAME_BITS = 80,
  parameter int SAMPLE_W   = 16
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  frame_valid_i,
  input  logic [FRAME_BITS-1:0] frame_bits_i,
  input  logic [15:0]           frame_crc_i,
  input  logic                  cmd_valid_i,
  input  logic [2:0]            cmd_op_i,
  input  logic                  smp_valid_i,
  input  logic [SAMPLE_W-1:0]   smp_left_i,
  input  logic [SAMPLE_W-1:0]   smp_right_i,
  input  logic                  host_clk_i,
  input  logic                  host_rw_i,
  input  logic                  host_cs_n_i,
  input  logic                  host_msb_first_i,
  output logic                  q_ready_o,
  output logic                  sq_dout_o,
  output logic                  sq_drive_o
);
  import qsub_pkg::*;

  logic addr_free_q, ready_q;
  logic crc_ok, adr_ok, accept_ok;
  logic frozen, release_ev, read_done, load;
  logic [SAMPLE_W-1:0] meter_word;

  assign load = frame_valid_i && !frozen;

  qsub_crc_gate #(.FRAME_BITS(FRAME_BITS)) u_gate (
    .frame_i     (frame_bits_i),
    .crc_word_i  (frame_crc_i),
    .addr_free_i (addr_free_q),
    .crc_ok_o    (crc_ok),
    .adr_ok_o    (adr_ok),
    .accept_ok_o (accept_ok)
  );

  qsub_meter #(.SAMPLE_W(SAMPLE_W)) u_meter (
    .clk          (clk),
    .rst_n        (rst_n),
    .smp_valid_i  (smp_valid_i),
    .smp_left_i   (smp_left_i),
    .smp_right_i  (smp_right_i),
    .cmd_valid_i  (cmd_valid_i),
    .cmd_op_i     (cmd_op_i),
    .read_done_i  (read_done),
    .meter_word_o (meter_word)
  );

  qsub_shifter #(.FRAME_BITS(FRAME_BITS), .WORD_W(SAMPLE_W)) u_shift (
    .clk              (clk),
    .rst_n            (rst_n),
    .host_clk_i       (host_clk_i),
    .host_rw_i        (host_rw_i),
    .host_cs_n_i      (host_cs_n_i),
    .host_msb_first_i (host_msb_first_i),
    .load_i           (load),
    .frame_i          (frame_bits_i),
    .meter_word_i     (meter_word),
    .frozen_o         (frozen),
    .release_o        (release_ev),
    .read_done_o      (read_done),
    .sq_dout_o        (sq_dout_o),
    .sq_drive_o       (sq_drive_o)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_free_q <= 1'b0;
      ready_q     <= 1'b0;
    end else begin
      if (cmd_valid_i && cmd_op_i == OP_ADDR_FREE) addr_free_q <= 1'b1;
      if (cmd_valid_i && cmd_op_i == OP_ADDR_ONE)  addr_free_q <= 1'b0;
      if (load)            ready_q <= accept_ok;
      else if (release_ev) ready_q <= 1'b0;
    end
  end

  assign q_ready_o = ready_q;

  // R1: the flag only rises on a frame strobe, and only for a passing check.
  p_ready_src_r1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ready_q) |-> ($past(frame_valid_i) && $past(crc_ok)));

  // R2: with the address check active, a raised flag implies address 1.
  p_ready_adr_r2: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(ready_q) && !$past(addr_free_q)) |-> $past(adr_ok));

  // R3: the flag is frozen together with the register.
  p_ready_frozen_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (frozen && $past(frozen)) |-> $stable(ready_q));
endmodule

// File: tb/qsub_readout_tb.sv
module qsub_readout_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        frame_valid = 1'b0;
  logic [79:0] frame_bits = '0;
  logic [15:0] frame_crc = '0;
  logic        cmd_valid = 1'b0;
  logic [2:0]  cmd_op = '0;
  logic        smp_valid = 1'b0;
  logic [15:0] smp_l = '0, smp_r = '0;
  logic        host_clk = 1'b1, host_rw = 1'b0, host_cs_n = 1'b1, host_msb = 1'b0;
  logic        q_ready, sq_dout, sq_drive;

  int checks = 0, errors = 0;
  bit done = 0;

  // Bench model of the meter state.
  logic [14:0] m_l = '0, m_r = '0, m_pk = '0;
  bit m_chl = 1, m_peak = 0, m_mask = 0, m_free = 0;
  logic [79:0] last_frame = '0;

  always #4 clk = ~clk;

  qsub_readout dut_i (
    .clk(clk), .rst_n(rst_n),
    .frame_valid_i(frame_valid), .frame_bits_i(frame_bits), .frame_crc_i(frame_crc),
    .cmd_valid_i(cmd_valid), .cmd_op_i(cmd_op),
    .smp_valid_i(smp_valid), .smp_left_i(smp_l), .smp_right_i(smp_r),
    .host_clk_i(host_clk), .host_rw_i(host_rw), .host_cs_n_i(host_cs_n),
    .host_msb_first_i(host_msb),
    .q_ready_o(q_ready), .sq_dout_o(sq_dout), .sq_drive_o(sq_drive)
  );

  task automatic check(input string req, input logic [95:0] act, input logic [95:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Bytewise CRC, byte 9 first.
  function automatic logic [15:0] bcrc(input logic [79:0] f);
    logic [15:0] c = '0;
    for (int k = 9; k >= 0; k--) begin
      c = c ^ {f[k*8 +: 8], 8'h00};
      for (int j = 0; j < 8; j++) c = c[15] ? ((c << 1) ^ 16'h1021) : (c << 1);
    end
    return c;
  endfunction

  function automatic logic [14:0] mag(input logic [15:0] s);
    int v = $signed(s);
    if (v < 0) v = -v;
    if (v > 32767) v = 32767;
    return v[14:0];
  endfunction

  function automatic logic [95:0] stream(input logic [79:0] f, input logic [15:0] w, input bit msb);
    logic [95:0] s;
    for (int b = 0; b < 10; b++)
      for (int j = 0; j < 8; j++) s[b*8+j] = msb ? f[b*8+7-j] : f[b*8+j];
    for (int j = 0; j < 16; j++) s[80+j] = msb ? w[15-j] : w[j];
    return s;
  endfunction

  function automatic logic [15:0] exp_word();
    if (m_peak) return {1'b0, m_pk};
    return {m_chl, m_chl ? m_l : m_r};
  endfunction

  task automatic do_cmd(input logic [2:0] op);
    @(negedge clk) begin cmd_valid = 1; cmd_op = op; end
    @(negedge clk) cmd_valid = 0;
    case (op)
      3'd1: m_free = 0;
      3'd2: m_free = 1;
      3'd3: begin m_peak = 0; m_pk = '0; end
      3'd4: begin m_peak = 1; m_l = '0; m_r = '0; end
      3'd5: m_mask = 1;
      3'd6: m_mask = 0;
      default: ;
    endcase
  endtask

  task automatic do_sample(input logic [15:0] l, input logic [15:0] r);
    logic [14:0] ml, mr;
    @(negedge clk) begin smp_valid = 1; smp_l = l; smp_r = r; end
    @(negedge clk) smp_valid = 0;
    ml = mag(l); mr = mag(r);
    if (!m_peak) begin
      if (ml > m_l) m_l = ml;
      if (mr > m_r) m_r = mr;
    end else if (!m_mask) begin
      if (ml > m_pk) m_pk = ml;
      if (mr > m_pk) m_pk = mr;
    end
  endtask

  task automatic send_frame(input logic [79:0] f, input logic [15:0] c);
    @(negedge clk) begin frame_valid = 1; frame_bits = f; frame_crc = c; end
    @(negedge clk) frame_valid = 0;
  endtask

  task automatic do_read(input int n, input bit msb, output logic [95:0] got);
    got = '0;
    host_msb = msb;
    host_cs_n = 0;
    for (int i = 0; i < n; i++) begin
      @(negedge clk) host_clk = 0;
      @(negedge clk) begin got[i] = sq_dout; host_clk = 1; end
    end
  endtask

  task automatic release_read(input bit full);
    @(negedge clk) host_rw = 1;
    @(negedge clk) host_rw = 0;
    @(negedge clk) host_cs_n = 1;
    if (full && !m_peak) begin
      if (m_chl) m_l = '0; else m_r = '0;
      m_chl = ~m_chl;
    end
  endtask

  function automatic logic [79:0] rnd_frame(input logic [3:0] adr);
    logic [79:0] f = {$urandom(), $urandom(), 16'($urandom())};
    f[3:0] = adr;
    return f;
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [95:0] got;
    logic [79:0] f, f2;
    logic [15:0] c, w;
    bit good, msb, exp_rdy;
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // Reset state
    check("R9 reset ready", q_ready, 0);
    check("R10 idle drive", sq_drive, 0);

    // R1: good frame with address 1
    f = rnd_frame(4'd1); send_frame(f, ~bcrc(f)); last_frame = f;
    check("R1 good adr1", q_ready, 1);
    f = rnd_frame(4'd2); send_frame(f, ~bcrc(f)); last_frame = f;
    check("R1 good adr2", q_ready, 0);
    f = rnd_frame(4'd1); send_frame(f, ~bcrc(f) ^ 16'h0100); last_frame = f;
    check("R1 bad crc", q_ready, 0);
    // R2: address free
    do_cmd(3'd2);
    f = rnd_frame(4'd3); send_frame(f, ~bcrc(f)); last_frame = f;
    check("R2 addr free", q_ready, 1);
    do_cmd(3'd1);
    f = rnd_frame(4'd3); send_frame(f, ~bcrc(f)); last_frame = f;
    check("R2 addr one restored", q_ready, 0);

    // R3 / R11: frame and samples during a read are ignored
    f = rnd_frame(4'd1); send_frame(f, ~bcrc(f)); last_frame = f;
    w = exp_word();
    do_read(1, 1, got);
    f2 = rnd_frame(4'd5); send_frame(f2, ~bcrc(f2) ^ 16'h1);
    check("R3 ready held while frozen", q_ready, 1);
    begin
      logic [95:0] rest;
      logic [14:0] sl = m_l, sr = m_r;
      do_sample(16'h7000, 16'h7000);
      do_read(95, 1, rest);
      got = {rest[94:0], got[0]};
      check("R3 frozen data", got, stream(last_frame, w, 1));
      m_l = sl; m_r = sr;
      m_l = 15'h7000; m_r = 15'h7000;
    end
    release_read(1);
    check("R3 ready cleared by strobe", q_ready, 0);

    // R10: clocking with chip select high has no effect
    host_cs_n = 1;
    repeat (4) begin
      @(negedge clk) host_clk = 0;
      @(negedge clk) host_clk = 1;
    end
    check("R10 drive off", {sq_drive, sq_dout}, 2'b00);
    f = rnd_frame(4'd1); send_frame(f, ~bcrc(f)); last_frame = f;
    check("R10 not frozen", q_ready, 1);
    w = exp_word();
    do_read(96, 0, got); release_read(1);
    check("R4 lsb-first read", got, stream(last_frame, w, 0));

    // R5: negative full scale limited, left reported
    do_cmd(3'd3);
    do_sample(16'h8000, 16'h0010);
    w = exp_word();
    check("R5 word model", w[15], m_chl);
    do_read(96, 1, got); release_read(1);
    check("R5 saturate meter", got[95:80], stream('0, w, 1) >> 80);
    // R6: channel swaps, right now
    w = exp_word();
    do_read(96, 1, got); release_read(1);
    check("R6 swap to right", got[95:80], stream('0, {1'b0, m_chl ? 15'h0 : 15'h0} | w, 1) >> 80);

    // R7/R8: peak with mask
    do_cmd(3'd4);
    do_sample(16'd100, 16'hFF9C);
    do_cmd(3'd5);
    do_sample(16'd2000, 16'd3000);
    w = exp_word();
    check("R8 masked peak", w, 16'd100);
    do_read(96, 0, got); release_read(1);
    check("R8 masked peak read", got[95:80], w);
    do_read(96, 0, got); release_read(1);
    check("R7 peak kept after read", got[95:80], w);
    do_cmd(3'd6);
    do_sample(16'd2000, 16'd3000);
    do_read(96, 0, got); release_read(1);
    check("R8 unmask", got[95:80], 16'd3000);
    // R9: back to level clears peak
    do_cmd(3'd3);
    w = exp_word();
    do_read(96, 0, got); release_read(1);
    check("R9 switch mode", got[95:80], w);

    // Random mix
    for (int it = 0; it < 40; it++) begin
      if ($urandom() % 3 == 0) do_cmd(3'(1 + $urandom() % 6));
      for (int s = 0; s < 4; s++)
        do_sample((s == 0 && it % 7 == 0) ? 16'h8000 : 16'($urandom()), 16'($urandom()));
      good = ($urandom() % 5) != 0;
      f = rnd_frame(($urandom() % 2) ? 4'd1 : 4'($urandom()));
      c = ~bcrc(f);
      if (!good) c = c ^ (16'h1 << ($urandom() % 16));
      send_frame(f, c); last_frame = f;
      exp_rdy = good && (m_free || f[3:0] == 4'd1);
      check("R1 random ready", q_ready, exp_rdy);
      msb = $urandom() % 2;
      w = exp_word();
      do_read(96, msb, got); release_read(1);
      check("R4 random stream", got, stream(last_frame, w, msb));
      check("R6 random release", q_ready, 0);
    end

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule